// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock calendar time: second, minute, hour, day of month, month, two-digit year and century. Software reaches it through a small word-addressed port with one valid strobe, a write flag, a byte address and 32-bit data. A parameterised divider turns the core clock into a one-second tick. On each tick the time moves forward one second while the clock is enabled. The carry chain covers month lengths, the leap-year rule over the full four-digit year, and the year rollover into the century.

The time is packed into two 32-bit words: the time-of-day word and the date word. Software may load either word, but only while the control register has its write-permission bit set. A load restarts the sub-second divider. A read of either word returns the running time while the clock is enabled. While it is disabled, the read returns the last stored image of that word, which is the last value loaded or the last value captured by an enabled read. Two further locations, alarm and alarm status, are kept in the map but do nothing.

Top module: `cal_rtc`

## Requirements
- R1: After reset the control register, both stored words and the running time are all zero. Every location reads as zero, and `rd_valid` is low until a read is made.
- R2: The time-of-day word, at byte offset 0x00, carries the day of month in bits 28:24, hours in bits 20:16, minutes in bits 13:8 and seconds in bits 5:0. All other bits read as zero.
- R3: The date word, at byte offset 0x04, carries the century in bits 20:16, the two-digit year in bits 14:8 and the month (1 to 12) in bits 3:0. All other bits read as zero.
- R4: The control register, at offset 0x10, accepts every write. Bit 0 is the run-enable flag and bit 1 is the write-permission flag. Other bits read as zero.
- R5: A write to offset 0x00 or 0x04 while control bit 1 is clear changes neither the running time nor the stored word.
- R6: A read of 0x00 or 0x04 returns the running time while control bit 0 is set, and also captures it into the stored word. While bit 0 is clear, the read returns the stored word.
- R7: Offsets 0x08, 0x0C and 0x14, and any offset at or above 0x18, read as zero. Writes to them change no state.
- R8: While enabled, time advances one second every `TICKS_PER_SEC` clock cycles. While disabled, it does not advance and the divider holds its count. A permitted counter write restarts the divider, so the first advance comes exactly `TICKS_PER_SEC` cycles after the load edge.
- R9: Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours. Hours roll from 23 to 0 and carry into the day.
- R10: The day rolls to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months. In month 2 it rolls after day 29 in a leap year and after day 28 otherwise. A leap year is one where century×100+year is divisible by 400, or is divisible by 4 but not by 100.
- R11: Month 12 rolls to 1 and increments the year. Year 99 rolls to 0 and increments the century.
- R12: A read request (valid high, write low) is answered on the next cycle: `rd_valid` is high and `bus_rdata` holds the value. In every other cycle `rd_valid` is low and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data strobe |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 4 and `ADDR_W` = 5. A short second means every calendar carry, from seconds up to the century, is reached within a few cycles of loading a time just before the boundary. It also lets the exact cycle of the first advance after a load be checked against reads made one edge before and one edge after it. With the 5-bit address, all eight word slots are reachable, including the unmapped ones. An interleaving of enable and disable with reads shows the difference between the stored image and the running time.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned DATA_W = 32;

    // Bits of each counter word that hold calendar fields.
    localparam logic [DATA_W-1:0] CLOCK_MASK = 32'h1F1F_3F3F;
    localparam logic [DATA_W-1:0] DATE_MASK  = 32'h001F_7F0F;

    typedef struct packed {
        logic [4:0] century;
        logic [6:0] year;
        logic [3:0] month;
        logic [4:0] mday;
        logic [4:0] hour;
        logic [5:0] minute;
        logic [5:0] second;
    } cal_time_t;

    typedef struct packed {
        logic wr_permit;
        logic run;
    } rtc_ctrl_t;

    typedef enum logic [2:0] {
        SLOT_CLOCK  = 3'd0,
        SLOT_DATE   = 3'd1,
        SLOT_ALARM  = 3'd2,
        SLOT_GAP    = 3'd3,
        SLOT_CTRL   = 3'd4,
        SLOT_ALSTAT = 3'd5,
        SLOT_HI0    = 3'd6,
        SLOT_HI1    = 3'd7
    } slot_e;

    function automatic logic [DATA_W-1:0] pack_clock(input cal_time_t t);
        return {3'b000, t.mday, 3'b000, t.hour, 2'b00, t.minute, 2'b00, t.second};
    endfunction

    function automatic logic [DATA_W-1:0] pack_date(input cal_time_t t);
        return {11'd0, t.century, 1'b0, t.year, 4'd0, t.month};
    endfunction

    function automatic logic leap_year(input logic [4:0] cent, input logic [6:0] yy);
        logic [11:0] full;
        full = 12'(cent) * 12'd100 + 12'(yy);
        return (((full % 12'd4) == 12'd0) && ((full % 12'd100) != 12'd0))
               || ((full % 12'd400) == 12'd0);
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
        logic [4:0] d;
        case (mon)
            4'd2:                      d = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   d = 5'd30;
            default:                   d = 5'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output slot_e             slot
);
    logic [2:0] word_idx;
    logic       above_window;

    assign word_idx = addr[4:2];

    generate
        if (ADDR_W > 5) begin : g_wide
            assign above_window = |addr[ADDR_W-1:5];
        end else begin : g_narrow
            assign above_window = 1'b0;
        end
    endgenerate

    always_comb begin
        if (above_window) slot = SLOT_GAP;
        else              slot = slot_e'(word_idx);
    end

endmodule

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == LAST);
    assign tick    = run && !restart && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ld_clock,
    input  logic              ld_date,
    input  logic [DATA_W-1:0] wdata,
    output cal_time_t         time_q
);
    cal_time_t  adv;
    cal_time_t  nxt;
    logic       leap;
    logic [4:0] last_day;
    logic       wrap_sec, wrap_min, wrap_hour, wrap_day, wrap_mon, wrap_year;

    assign leap      = leap_year(time_q.century, time_q.year);
    assign last_day  = month_days(time_q.month, leap);

    assign wrap_sec  = (time_q.second >= 6'd59);
    assign wrap_min  = (time_q.minute >= 6'd59);
    assign wrap_hour = (time_q.hour   >= 5'd23);
    assign wrap_day  = (time_q.mday   >= last_day);
    assign wrap_mon  = (time_q.month  >= 4'd12);
    assign wrap_year = (time_q.year   >= 7'd99);

    // One-second advance with the full carry chain.
    always_comb begin
        adv = time_q;
        if (!wrap_sec) begin
            adv.second = time_q.second + 6'd1;
        end else begin
            adv.second = '0;
            if (!wrap_min) begin
                adv.minute = time_q.minute + 6'd1;
            end else begin
                adv.minute = '0;
                if (!wrap_hour) begin
                    adv.hour = time_q.hour + 5'd1;
                end else begin
                    adv.hour = '0;
                    if (!wrap_day) begin
                        adv.mday = time_q.mday + 5'd1;
                    end else begin
                        adv.mday = 5'd1;
                        if (!wrap_mon) begin
                            adv.month = time_q.month + 4'd1;
                        end else begin
                            adv.month = 4'd1;
                            if (!wrap_year) begin
                                adv.year = time_q.year + 7'd1;
                            end else begin
                                adv.year    = '0;
                                adv.century = time_q.century + 5'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        nxt = tick ? adv : time_q;
        if (ld_clock) begin
            nxt.mday   = wdata[28:24];
            nxt.hour   = wdata[20:16];
            nxt.minute = wdata[13:8];
            nxt.second = wdata[5:0];
        end
        if (ld_date) begin
            nxt.century = wdata[20:16];
            nxt.year    = wdata[14:8];
            nxt.month   = wdata[3:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) time_q <= '0;
        else     time_q <= nxt;
    end

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import rtc_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned ADDR_W        = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rd_valid
);
    slot_e       slot;
    rtc_ctrl_t   ctrl_q;
    cal_time_t   live_q;
    logic [31:0] clock_img_q;
    logic [31:0] date_img_q;
    logic [31:0] rd_mux;
    logic        wr_req, rd_req;
    logic        ld_clock, ld_date;
    logic        sec_tick;

    assign wr_req   = bus_valid && bus_write;
    assign rd_req   = bus_valid && !bus_write;
    assign ld_clock = wr_req && (slot == SLOT_CLOCK) && ctrl_q.wr_permit;
    assign ld_date  = wr_req && (slot == SLOT_DATE)  && ctrl_q.wr_permit;

    rtc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .slot (slot)
    );

    rtc_sec_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .restart (ld_clock || ld_date),
        .tick    (sec_tick)
    );

    rtc_calendar u_cal (
        .clk      (clk),
        .rst      (rst),
        .tick     (sec_tick),
        .ld_clock (ld_clock),
        .ld_date  (ld_date),
        .wdata    (bus_wdata),
        .time_q   (live_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_req && slot == SLOT_CTRL) begin
            ctrl_q <= rtc_ctrl_t'(bus_wdata[1:0]);
        end
    end

    // Stored images: loaded by permitted writes, captured by enabled reads.
    always_ff @(posedge clk) begin
        if (rst) begin
            clock_img_q <= '0;
            date_img_q  <= '0;
        end else begin
            if (ld_clock)
                clock_img_q <= bus_wdata & CLOCK_MASK;
            else if (rd_req && slot == SLOT_CLOCK && ctrl_q.run)
                clock_img_q <= pack_clock(live_q);
            if (ld_date)
                date_img_q <= bus_wdata & DATE_MASK;
            else if (rd_req && slot == SLOT_DATE && ctrl_q.run)
                date_img_q <= pack_date(live_q);
        end
    end

    always_comb begin
        case (slot)
            SLOT_CLOCK: rd_mux = ctrl_q.run ? pack_clock(live_q) : clock_img_q;
            SLOT_DATE:  rd_mux = ctrl_q.run ? pack_date(live_q)  : date_img_q;
            SLOT_CTRL:  rd_mux = {30'd0, ctrl_q};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            rd_valid  <= 1'b0;
        end else begin
            bus_rdata <= rd_req ? rd_mux : '0;
            rd_valid  <= rd_req;
        end
    end

endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              rd_valid,
    input cal_time_t         live,
    input rtc_ctrl_t         ctrl,
    input logic              tick
);
    logic [ADDR_W-1:0] widx;
    logic              cnt_wr;
    logic              dead_rd;

    assign widx    = bus_addr >> 2;
    assign cnt_wr  = bus_valid && bus_write && (widx < ADDR_W'(2));
    assign dead_rd = bus_valid && !bus_write &&
                     (widx == ADDR_W'(2) || widx == ADDR_W'(3) || widx >= ADDR_W'(5));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!rd_valid && ctrl == '0 && live == '0));

    // R12
    rd_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> rd_valid);

    // R12
    rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> (!rd_valid && bus_rdata == '0));

    // R7
    dead_slot_chk: assert property (@(posedge clk) disable iff (rst)
        dead_rd |=> (bus_rdata == '0));

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cnt_wr) |=> $stable(live));

    // R5
    locked_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !ctrl.wr_permit && !tick) |=> $stable(live));

    // R9
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && live.second < 6'd59) |=> (live.second == 6'($past(live.second) + 6'd1)));

endmodule

bind cal_rtc cal_rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .rd_valid  (rd_valid),
    .live      (live_q),
    .ctrl      (ctrl_q),
    .tick      (sec_tick)
);

// File: tb/cal_rtc_tb.sv
`timescale 1ns/1ps
module cal_rtc_tb;

    localparam int unsigned T  = 4;
    localparam int unsigned AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr  = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          rd_valid;

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    done   = 1'b0;

    always #2.5 clk = ~clk;

    cal_rtc #(.TICKS_PER_SEC(T), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rd_valid(rd_valid)
    );

    // ---------------- behavioural reference model ----------------
    int          m_sec, m_min, m_hr, m_mday, m_mon, m_yr, m_cen, m_div;
    bit          m_en, m_unl, m_rv;
    logic [31:0] m_clk_img, m_date_img, m_rdata;

    function automatic int days_of(int mon, int cen, int yr);
        int full;
        bit lp;
        full = cen * 100 + yr;
        lp = ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
        if (mon == 2) return lp ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] live_clock();
        return {3'b0, 5'(m_mday), 3'b0, 5'(m_hr), 2'b0, 6'(m_min), 2'b0, 6'(m_sec)};
    endfunction

    function automatic logic [31:0] live_date();
        return {11'b0, 5'(m_cen), 1'b0, 7'(m_yr), 4'b0, 4'(m_mon)};
    endfunction

    task automatic model_advance();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hr++;
        if (m_hr < 24) return;
        m_hr = 0;
        if (m_mday < days_of(m_mon, m_cen, m_yr)) begin m_mday++; return; end
        m_mday = 1;
        if (m_mon < 12) begin m_mon++; return; end
        m_mon = 1;
        if (m_yr < 99) begin m_yr++; return; end
        m_yr = 0;
        m_cen = (m_cen + 1) % 32;
    endtask

    always @(posedge clk) begin
        int          slot;
        bit          wr, rd, ld1, ld2, tk;
        logic [31:0] rv;
        if (rst) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_mday = 0; m_mon = 0; m_yr = 0; m_cen = 0;
            m_div = 0; m_en = 0; m_unl = 0; m_rv = 0;
            m_clk_img = '0; m_date_img = '0; m_rdata = '0;
        end else begin
            slot = int'(bus_addr) / 4;
            wr = bus_valid && bus_write;
            rd = bus_valid && !bus_write;
            case (slot)
                0:       rv = m_en ? live_clock() : m_clk_img;
                1:       rv = m_en ? live_date()  : m_date_img;
                4:       rv = {30'b0, m_unl, m_en};
                default: rv = '0;
            endcase
            ld1 = wr && slot == 0 && m_unl;
            ld2 = wr && slot == 1 && m_unl;
            tk  = m_en && !(ld1 || ld2) && (m_div == T - 1);
            if (rd && m_en && slot == 0) m_clk_img  = live_clock();
            if (rd && m_en && slot == 1) m_date_img = live_date();
            if (ld1 || ld2)  m_div = 0;
            else if (m_en)   m_div = (m_div == T - 1) ? 0 : m_div + 1;
            if (tk) model_advance();
            if (ld1) begin
                m_clk_img = bus_wdata & 32'h1F1F_3F3F;
                m_mday = int'(bus_wdata[28:24]); m_hr  = int'(bus_wdata[20:16]);
                m_min  = int'(bus_wdata[13:8]);  m_sec = int'(bus_wdata[5:0]);
            end
            if (ld2) begin
                m_date_img = bus_wdata & 32'h001F_7F0F;
                m_cen = int'(bus_wdata[20:16]); m_yr = int'(bus_wdata[14:8]);
                m_mon = int'(bus_wdata[3:0]);
            end
            if (wr && slot == 4) begin m_en = bus_wdata[0]; m_unl = bus_wdata[1]; end
            m_rdata = rd ? rv : '0;
            m_rv    = rd;
        end
    end

    // Every-cycle comparison against the model (R12 timing plus current phase).
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (bus_rdata !== m_rdata || rd_valid !== m_rv) begin
                errors++;
                $display("FAIL %s model compare: rdata=%h rd_valid=%b expected rdata=%h rd_valid=%b",
                         phase, bus_rdata, rd_valid, m_rdata, m_rv);
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        checks++;
        if (bus_rdata !== exp || rd_valid !== 1'b1) begin
            errors++;
            $display("FAIL %s: addr %h read %h (valid %b) expected %h", req, a, bus_rdata, rd_valid, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic roll(input logic [31:0] c, input logic [31:0] d,
                        input logic [31:0] ec, input logic [31:0] ed, input string req);
        phase = req;
        bus_wr(5'h00, c);
        bus_wr(5'h04, d);
        idle(T);
        rd_chk(5'h00, ec, req);
        rd_chk(5'h04, ed, req);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        phase = "R1";
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rd_valid %b expected 0", rd_valid);
        end
        for (int i = 0; i < 8; i++) rd_chk(AW'(i * 4), 32'h0, "R1");

        // R5: counter writes dropped while locked
        phase = "R5";
        bus_wr(5'h00, 32'h0F0A_141E);
        rd_chk(5'h00, 32'h0, "R5");
        bus_wr(5'h04, 32'h0014_1802);
        rd_chk(5'h04, 32'h0, "R5");

        // R4: control accepts anything, keeps bits 1:0
        phase = "R4";
        bus_wr(5'h10, 32'hFFFF_FFFE);
        rd_chk(5'h10, 32'h2, "R4");

        // R2 / R3: field layout, reserved bits dropped
        phase = "R2";
        bus_wr(5'h00, 32'hEF0A_141E);
        rd_chk(5'h00, 32'h0F0A_141E, "R2");
        phase = "R3";
        bus_wr(5'h04, 32'hFFF4_98F2);
        rd_chk(5'h04, 32'h0014_1802, "R3");

        // R7: dead locations
        phase = "R7";
        bus_wr(5'h08, 32'hFFFF_FFFF);
        bus_wr(5'h0C, 32'hFFFF_FFFF);
        bus_wr(5'h14, 32'hFFFF_FFFF);
        bus_wr(5'h18, 32'hFFFF_FFFF);
        rd_chk(5'h08, 32'h0, "R7");
        rd_chk(5'h0C, 32'h0, "R7");
        rd_chk(5'h14, 32'h0, "R7");
        rd_chk(5'h18, 32'h0, "R7");
        rd_chk(5'h1C, 32'h0, "R7");
        rd_chk(5'h00, 32'h0F0A_141E, "R7");
        rd_chk(5'h10, 32'h2, "R7");

        // R8: first advance exactly T cycles after the load edge
        phase = "R8";
        bus_wr(5'h10, 32'h3);
        bus_wr(5'h00, 32'h0F0A_141E);
        idle(T - 2);
        rd_chk(5'h00, 32'h0F0A_141E, "R8");
        rd_chk(5'h00, 32'h0F0A_141E, "R8");
        rd_chk(5'h00, 32'h0F0A_141F, "R8");

        // R9 / R10 / R11: carry chain
        roll(32'h050A_143B, 32'h0014_1705, 32'h050A_1500, 32'h0014_1705, "R9");
        roll(32'h050A_3B3B, 32'h0014_1705, 32'h050B_0000, 32'h0014_1705, "R9");
        roll(32'h1C17_3B3B, 32'h0014_1802, 32'h1D00_0000, 32'h0014_1802, "R10");
        roll(32'h1C17_3B3B, 32'h0014_1702, 32'h0100_0000, 32'h0014_1703, "R10");
        roll(32'h1C17_3B3B, 32'h0015_0002, 32'h0100_0000, 32'h0015_0003, "R10");
        roll(32'h1C17_3B3B, 32'h0014_0002, 32'h1D00_0000, 32'h0014_0002, "R10");
        roll(32'h1E17_3B3B, 32'h0014_1704, 32'h0100_0000, 32'h0014_1705, "R10");
        roll(32'h1F17_3B3B, 32'h0014_1701, 32'h0100_0000, 32'h0014_1702, "R10");
        roll(32'h1F17_3B3B, 32'h0014_630C, 32'h0100_0000, 32'h0015_0001, "R11");
        roll(32'h1F17_3B3B, 32'h0014_170C, 32'h0100_0000, 32'h0014_1801, "R11");

        // R6: stored image versus running time
        phase = "R6";
        bus_wr(5'h00, 32'h050A_1400);
        bus_wr(5'h04, 32'h0014_1705);
        idle(2 * T + 1);
        bus_wr(5'h10, 32'h2);
        rd_chk(5'h00, 32'h050A_1400, "R6");
        bus_wr(5'h10, 32'h3);
        rd_chk(5'h00, 32'h050A_1402, "R6");
        bus_wr(5'h10, 32'h2);
        rd_chk(5'h00, 32'h050A_1402, "R6");

        // R8: nothing advances while disabled
        phase = "R8";
        idle(20);
        bus_wr(5'h10, 32'h3);
        rd_chk(5'h00, 32'h050A_1403, "R8");

        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule